// File: doc/BRIEF.md
# Prioritized Interrupt Capture Unit

This block collects sixteen interrupt request lines into a pending register. It qualifies the pending register with a software mask and tells the control sequencer which level to service next. Request lines are sampled only on a machine-cycle-start strobe. Edge-like anti-repeat logic makes sure that a line held high is recorded once, not on every cycle start. A pending level stays recorded while it is masked, and it takes effect as soon as its mask bit is set.

A separate sixteen-bit fault register collects fault inputs on the same strobe. Its bits stay set until software clears them. While any fault bit is set, the block presents a machine-error request on interrupt level 1. The outputs are a request flag and the binary number of the winning level. Level 0 is the most urgent, and it cannot be masked.

Top module: `icu_top`

## Requirements
- R1: After reset the pending, mask and fault registers are all zero, so `irq_req_o` is 0 and `irq_vec_o` is 0.
- R2: A request line is recorded in the pending register only in a cycle where `cyc_start_i` is 1. A line that is high in other cycles has no effect.
- R3: Anti-repeat: a line recorded at one cycle start is not recorded again until it has been seen low at a later cycle start. This holds even if software has cleared its pending bit in between.
- R4: Mask bit k = 0 blocks level k from the request. The pending bit is kept, and the level is requested from the cycle after its mask bit is written to 1.
- R5: Level 0 is requested whenever it is pending, whatever mask bit 0 holds.
- R6: Among requested levels, the lowest level number wins.
- R7: If a bit of `pend_clr_i` is 1 in the same cycle as a capture of that level, the clear wins and the bit stays 0.
- R8: Fault inputs are captured only at a cycle start, with 1 meaning a fault. While any fault bit is set, level 1 is requested, subject to mask bit 1.
- R9: A fault bit stays set until the matching `flt_clr_i` bit is 1. Clearing pending bit 1 does not clear it.
- R10: `irq_vec_o` is the winning level number in binary. It is 0 whenever `irq_req_o` is 0. Both outputs reflect register state from the cycle after any update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Machine-cycle-start strobe; enables capture |
| irq_i | input | 16 | Raw interrupt request lines, bit k = level k |
| flt_i | input | 16 | Raw fault inputs |
| pend_clr_i | input | 16 | Software clear of pending bits, one per level |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 16 | Mask write data, 1 = level enabled |
| flt_clr_i | input | 16 | Software clear of fault bits |
| irq_req_o | output | 1 | At least one enabled pending level |
| irq_vec_o | output | 4 | Number of the winning level |

## Verification
The level lines are tried in several patterns. A line held high with no strobe separates sampling on cycle start from free-running capture. A line held across several strobes, with a software clear in between, separates edge capture from level capture. Driving three lines on one strobe and then clearing them one by one walks the priority order. Masked-then-unmasked and level-0-masked patterns show that masking gates the request without dropping the record. A fault pulse that goes away shows that the level 1 request remains until its own clear. A long stretch of sparse random stimulus is also compared on every clock against a behavioural model.

// File: rtl/icu_pkg.sv
package icu_pkg;
  parameter int unsigned ICU_LEVELS    = 16;
  parameter int unsigned ICU_FLT_BITS  = 16;
  parameter int unsigned ICU_FAULT_LVL = 1;
endpackage

// File: rtl/icu_pend_capture.sv
module icu_pend_capture #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cyc_start_i,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] seen_q;

  for (genvar k = 0; k < N; k++) begin : g_lvl
    logic cap;
    assign cap = cyc_start_i & irq_i[k] & ~seen_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seen_q[k] <= 1'b0;
        pend_o[k] <= 1'b0;
      end else begin
        if (cyc_start_i) seen_q[k] <= irq_i[k];
        // clear dominates a same-cycle capture
        if (clr_i[k])     pend_o[k] <= 1'b0;
        else if (cap)     pend_o[k] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/icu_fault_reg.sv
module icu_fault_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cyc_start_i,
  input  logic [W-1:0] flt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flt_o,
  output logic         any_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       flt_o[k] <= 1'b0;
      else if (clr_i[k])                 flt_o[k] <= 1'b0;
      else if (cyc_start_i && flt_i[k])  flt_o[k] <= 1'b1;
    end
  end

  assign any_o = |flt_o;
endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc #(
  parameter int unsigned N = 16,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] act_i,
  output logic         req_o,
  output logic [W-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) vec_o = W'(i);
    end
  end

  assign req_o = |act_i;
endmodule

// File: rtl/icu_top.sv
module icu_top #(
  parameter int unsigned NUM_LVL   = icu_pkg::ICU_LEVELS,
  parameter int unsigned FLT_W     = icu_pkg::ICU_FLT_BITS,
  parameter int unsigned FAULT_LVL = icu_pkg::ICU_FAULT_LVL,
  localparam int unsigned LVL_W    = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cyc_start_i,
  input  logic [NUM_LVL-1:0] irq_i,
  input  logic [FLT_W-1:0]   flt_i,
  input  logic [NUM_LVL-1:0] pend_clr_i,
  input  logic               mask_we_i,
  input  logic [NUM_LVL-1:0] mask_wdata_i,
  input  logic [FLT_W-1:0]   flt_clr_i,
  output logic               irq_req_o,
  output logic [LVL_W-1:0]   irq_vec_o
);
  logic [NUM_LVL-1:0] pend_q;
  logic [NUM_LVL-1:0] mask_q;
  logic [FLT_W-1:0]   flt_q;
  logic               flt_any;
  logic [NUM_LVL-1:0] eff_pend;
  logic [NUM_LVL-1:0] allow;
  logic [NUM_LVL-1:0] act;

  icu_pend_capture #(.N(NUM_LVL)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_start_i(cyc_start_i),
    .irq_i      (irq_i),
    .clr_i      (pend_clr_i),
    .pend_o     (pend_q)
  );

  icu_fault_reg #(.W(FLT_W)) u_flt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_start_i(cyc_start_i),
    .flt_i      (flt_i),
    .clr_i      (flt_clr_i),
    .flt_o      (flt_q),
    .any_o      (flt_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  // fault summary is a live source on the machine-error level
  assign eff_pend = pend_q | (NUM_LVL'(flt_any) << FAULT_LVL);
  // level 0 is never maskable
  assign allow    = mask_q | NUM_LVL'(1);
  assign act      = eff_pend & allow;

  icu_prio_enc #(.N(NUM_LVL)) u_enc (
    .act_i(act),
    .req_o(irq_req_o),
    .vec_o(irq_vec_o)
  );
endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int unsigned NUM_LVL   = 16,
  parameter int unsigned FLT_W     = 16,
  parameter int unsigned FAULT_LVL = 1,
  localparam int unsigned LVL_W    = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cyc_start_i,
  input logic [NUM_LVL-1:0] pend_clr_i,
  input logic [FLT_W-1:0]   flt_clr_i,
  input logic [NUM_LVL-1:0] pend_q,
  input logic [NUM_LVL-1:0] mask_q,
  input logic [FLT_W-1:0]   flt_q,
  input logic               irq_req_o,
  input logic [LVL_W-1:0]   irq_vec_o
);
  assert_no_capture_off_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_start_i |=> ((pend_q & ~$past(pend_q)) == '0));

  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_i != '0) |=> ((pend_q & $past(pend_clr_i)) == '0));

  assert_fault_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_clr_i == '0) |=> ((~flt_q & $past(flt_q)) == '0));

  assert_lvl0_unmaskable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[0] |-> (irq_req_o && irq_vec_o == '0));

  assert_idle_vec_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> (irq_vec_o == '0));

  assert_fault_requests_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flt_q != '0) && mask_q[FAULT_LVL]) |-> irq_req_o);
endmodule

bind icu_top icu_checker #(
  .NUM_LVL  (NUM_LVL),
  .FLT_W    (FLT_W),
  .FAULT_LVL(FAULT_LVL)
) u_icu_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cyc_start_i(cyc_start_i),
  .pend_clr_i (pend_clr_i),
  .flt_clr_i  (flt_clr_i),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .flt_q      (flt_q),
  .irq_req_o  (irq_req_o),
  .irq_vec_o  (irq_vec_o)
);

// File: tb/tb_icu_top.sv
`timescale 1ns/1ps
module tb_icu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_start = 1'b0;
  logic [15:0] irq = '0, flt = '0, pend_clr = '0, mask_wd = '0, flt_clr = '0;
  logic        mask_we = 1'b0;
  logic        req;
  logic [3:0]  vec;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  icu_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(cyc_start), .irq_i(irq),
    .flt_i(flt), .pend_clr_i(pend_clr), .mask_we_i(mask_we),
    .mask_wdata_i(mask_wd), .flt_clr_i(flt_clr),
    .irq_req_o(req), .irq_vec_o(vec)
  );

  // behavioural reference model
  bit [15:0] m_pend, m_mask, m_flt, m_seen;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 0; m_mask <= 0; m_flt <= 0; m_seen <= 0;
    end else begin
      bit [15:0] np, nf;
      np = m_pend; nf = m_flt;
      for (int i = 0; i < 16; i++) begin
        if (cyc_start && irq[i] && !m_seen[i]) np[i] = 1;
        if (pend_clr[i]) np[i] = 0;
        if (cyc_start && flt[i]) nf[i] = 1;
        if (flt_clr[i]) nf[i] = 0;
      end
      m_pend <= np; m_flt <= nf;
      if (cyc_start) m_seen <= irq;
      if (mask_we) m_mask <= mask_wd;
    end
  end

  function automatic void model_out(output bit r, output int v);
    r = 0; v = 0;
    for (int i = 0; i < 16; i++) begin
      bit pend_i, en_i;
      pend_i = m_pend[i] || (i == 1 && m_flt != 0);
      en_i   = m_mask[i] || i == 0;
      if (pend_i && en_i && !r) begin r = 1; v = i; end
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit er; int ev;
      model_out(er, ev);
      checks++;
      if (req !== er || (er && vec !== 4'(ev)) || (!er && vec !== 4'd0)) begin
        fails++;
        $display("FAIL R6 R10 model compare: req=%0b vec=%0d expected req=%0b vec=%0d",
                 req, vec, er, ev);
      end
    end
  end

  task automatic chk(input bit er, input int ev, input string tag);
    checks++;
    if (req !== er || vec !== 4'(ev)) begin
      fails++;
      $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d", tag, req, vec, er, ev);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic pulse_cs(); cyc_start = 1; tick(); cyc_start = 0; endtask
  task automatic clr_pend(input logic [15:0] m); pend_clr = m; tick(); pend_clr = 0; endtask
  task automatic wr_mask(input logic [15:0] m);
    mask_we = 1; mask_wd = m; tick(); mask_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(0, 0, "R1 reset state");

    wr_mask(16'hFFFF);
    irq = 16'h0020; tick(); tick();
    chk(0, 0, "R2 no strobe no capture");
    pulse_cs();
    chk(1, 5, "R2 capture on strobe");

    clr_pend(16'h0020);
    chk(0, 0, "R3 cleared");
    pulse_cs();
    chk(0, 0, "R3 held line not recaptured");
    irq = 0; pulse_cs();
    irq = 16'h0020; pulse_cs();
    chk(1, 5, "R3 recapture after release");

    clr_pend(16'h0020);
    irq = 0; pulse_cs();
    irq = 16'h0020; cyc_start = 1; pend_clr = 16'h0020; tick();
    cyc_start = 0; pend_clr = 0;
    chk(0, 0, "R7 clear beats capture");
    irq = 0; pulse_cs();

    irq = 16'h1208; pulse_cs(); irq = 0;
    chk(1, 3, "R6 lowest wins");
    clr_pend(16'h0008);
    chk(1, 9, "R6 next level");
    clr_pend(16'h0200);
    chk(1, 12, "R6 last level");
    clr_pend(16'h1000);
    chk(0, 0, "R10 idle vector");
    pulse_cs();

    wr_mask(16'h0000);
    irq = 16'h0010; pulse_cs(); irq = 0;
    chk(0, 0, "R4 masked pending");
    wr_mask(16'h0010);
    chk(1, 4, "R4 unmasked takes effect");
    clr_pend(16'h0010);

    wr_mask(16'h0000);
    irq = 16'h0001; pulse_cs(); irq = 0;
    chk(1, 0, "R5 level 0 unmaskable");
    clr_pend(16'h0001);
    chk(0, 0, "R5 level 0 cleared");
    pulse_cs();

    wr_mask(16'hFFFF);
    flt = 16'h0080; tick();
    chk(0, 0, "R8 fault needs strobe");
    pulse_cs();
    chk(1, 1, "R8 fault raises level 1");
    flt = 0; pulse_cs(); pulse_cs();
    chk(1, 1, "R9 fault sticky");
    wr_mask(16'hFFFD);
    chk(0, 0, "R8 mask bit 1 blocks fault");
    wr_mask(16'hFFFF);
    clr_pend(16'h0002);
    chk(1, 1, "R9 pending clear keeps fault");
    irq = 16'h0001; pulse_cs(); irq = 0;
    chk(1, 0, "R6 level 0 over fault");
    clr_pend(16'h0001);
    chk(1, 1, "R6 fault after level 0");
    flt_clr = 16'h0080; tick(); flt_clr = 0;
    chk(0, 0, "R9 fault cleared");
    pulse_cs();

    for (int n = 0; n < 600; n++) begin
      irq       = 16'($urandom) & 16'($urandom) & 16'($urandom);
      flt       = (($urandom % 16) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      cyc_start = ($urandom % 3) == 0;
      pend_clr  = 16'($urandom) & 16'($urandom);
      flt_clr   = (($urandom % 8) == 0) ? 16'($urandom) : 16'h0;
      mask_we   = ($urandom % 10) == 0;
      mask_wd   = 16'($urandom);
      tick();
    end
    irq = 0; flt = 0; cyc_start = 0; pend_clr = 0; flt_clr = 0; mask_we = 0;
    tick(); tick();
    finish_run();
  end
endmodule